// File: doc/BRIEF.md
# Burst Address Sequencer with Wrap

This block holds the registered access address of a synchronous burst memory. On a clock edge where an address strobe takes effect and all three chip enables are active, it captures a new external address and selects the device. Each later edge can step the two low address bits through a four-beat burst. The upper bits stay fixed for the whole burst.

There are two address strobes, and they are gated differently. The processor strobe is masked whenever the master enable is inactive. The controller strobe is never masked by the master enable, but it only acts when the processor strobe has not already taken the edge. Any inactive enable on an edge where a strobe acts deselects the device.

A static mode input picks the burst order:
- **Interleaved:** the start bits XOR a beat count.
- **Linear:** the start bits plus the beat count, modulo 4.

The beat count is two bits wide, so the sequence wraps after four beats.

Top module: `burst_addr_seq`

## Requirements
- R1: When the processor strobe is low and all enables are active (master low, second high, third low), the next cycle shows `acc_addr` equal to the sampled `ext_addr` and `selected` high.
- R2: A low processor strobe with the master enable high (inactive), while the controller strobe is high, changes nothing: `acc_addr`, `selected` and `desel_pulse` keep their previous values.
- R3: The controller strobe takes effect when it is low and the processor strobe is not in effect, even with the master enable inactive. With all enables active it loads the address exactly as in R1.
- R4: On an edge that loads an address, the advance input is ignored, so the first beat is the loaded address itself.
- R5: While selected, an edge with advance low and both strobes high steps to the next beat. An edge with advance high, or with either strobe low and no strobe in effect, holds `acc_addr`.
- R6: With `interleave_mode`=1, beat k has low bits equal to the start bits XOR k. With `interleave_mode`=0, beat k has low bits equal to (start + k) mod 4.
- R7: Bits [16:2] of `acc_addr` change only on a load edge, never during a burst.
- R8: An edge where a strobe takes effect with any enable inactive makes `selected` low, leaves `acc_addr` unchanged, and raises `desel_pulse` for exactly the following cycle.
- R9: After four advances the burst wraps, so the fifth beat equals the start address.
- R10: During and after reset, `acc_addr` is 0, `selected` is 0 and `desel_pulse` is 0.
- R11: Advance requests while deselected leave `acc_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | 17 | External address |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| en_master_n | input | 1 | Master chip enable, active low |
| en_hi | input | 1 | Second chip enable, active high |
| en_lo_n | input | 1 | Third chip enable, active low |
| interleave_mode | input | 1 | 1 = XOR burst order, 0 = linear order |
| acc_addr | output | 17 | Current access address |
| selected | output | 1 | Device selected |
| desel_pulse | output | 1 | One-cycle flag after a deselecting edge |

## Verification
The bench drives the processor strobe with the master enable inactive. A design that fails to block it would load a stray address or deselect.

It also gives the controller strobe alone an inactive master enable. A design that copies the processor gating there would wrongly ignore that edge.

Loads are issued with advance held low. A design that advances on the load edge would skip the first beat.

Bursts run past four beats in both orders and from non-zero start values. Carry leaking into bit 2, a wrong order, or a missing wrap would each show up as a wrong address. Deselecting edges are made with each enable in turn, and advance is requested while deselected.

// File: rtl/bas_pkg.sv
package bas_pkg;

  // What an edge does to the sequencer state
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_DESEL   = 2'd2,
    ACT_ADVANCE = 2'd3
  } edge_act_e;

  // Low address bits of beat 'beat' starting from 'start'
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       xor_order);
    logic [1:0] r;
    if (xor_order) r = start ^ beat;
    else           r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/bas_edge_decode.sv
module bas_edge_decode
  import bas_pkg::*;
(
  input  logic      proc_strobe_n,
  input  logic      ctrl_strobe_n,
  input  logic      advance_n,
  input  logic      en_master_n,
  input  logic      en_hi,
  input  logic      en_lo_n,
  input  logic      sel_q,
  output edge_act_e act
);
  logic proc_eff, ctrl_eff, all_en;

  always_comb begin
    proc_eff = !proc_strobe_n && !en_master_n;
    ctrl_eff = !ctrl_strobe_n && !proc_eff;
    all_en   = !en_master_n && en_hi && !en_lo_n;
    act      = ACT_HOLD;
    if (proc_eff || ctrl_eff) begin
      act = all_en ? ACT_LOAD : ACT_DESEL;
    end else if (proc_strobe_n && ctrl_strobe_n && !advance_n && sel_q) begin
      act = ACT_ADVANCE;
    end
  end
endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (clr)  beat <= '0;
    else if (step) beat <= beat + 1'b1;
  end
endmodule

// File: rtl/bas_base_reg.sv
module bas_base_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              desel,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] base,
  output logic              sel_q,
  output logic              desel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base    <= '0;
      sel_q   <= 1'b0;
      desel_q <= 1'b0;
    end else begin
      desel_q <= desel;
      if (load) begin
        base  <= d;
        sel_q <= 1'b1;
      end else if (desel) begin
        sel_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              en_master_n,
  input  logic              en_hi,
  input  logic              en_lo_n,
  input  logic              interleave_mode,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              selected,
  output logic              desel_pulse
);
  localparam int BEAT_W = 2;

  edge_act_e         act;
  logic              load_evt, desel_evt, adv_evt;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;
  logic              sel_q;

  bas_edge_decode u_dec (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .en_master_n   (en_master_n),
    .en_hi         (en_hi),
    .en_lo_n       (en_lo_n),
    .sel_q         (sel_q),
    .act           (act)
  );

  assign load_evt  = (act == ACT_LOAD);
  assign desel_evt = (act == ACT_DESEL);
  assign adv_evt   = (act == ACT_ADVANCE);

  bas_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_evt),
    .step  (adv_evt),
    .beat  (beat)
  );

  bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_evt),
    .desel   (desel_evt),
    .d       (ext_addr),
    .base    (base),
    .sel_q   (sel_q),
    .desel_q (desel_pulse)
  );

  assign acc_addr = {base[ADDR_W-1:BEAT_W],
                     beat_low(base[BEAT_W-1:0], beat, interleave_mode)};
  assign selected = sel_q;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              advance_n,
  input logic              en_master_n,
  input logic              interleave_mode,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              selected,
  input logic              desel_pulse,
  input logic              load_evt,
  input logic              desel_evt
);
  // R1
  load_takes_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (acc_addr == $past(ext_addr)) && selected);

  // R2
  proc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && en_master_n && ctrl_strobe_n) |=>
      (!$stable(interleave_mode) || $stable(acc_addr)) && $stable(selected));

  // R5
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_n && proc_strobe_n && ctrl_strobe_n) |=>
      (!$stable(interleave_mode) || $stable(acc_addr)));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(acc_addr[ADDR_W-1:2]));

  // R8
  desel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_evt |=> !selected && desel_pulse);

  // R8
  desel_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !desel_evt |=> !desel_pulse);
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ext_addr        (ext_addr),
  .proc_strobe_n   (proc_strobe_n),
  .ctrl_strobe_n   (ctrl_strobe_n),
  .advance_n       (advance_n),
  .en_master_n     (en_master_n),
  .interleave_mode (interleave_mode),
  .acc_addr        (acc_addr),
  .selected        (selected),
  .desel_pulse     (desel_pulse),
  .load_evt        (load_evt),
  .desel_evt       (desel_evt)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] ext_addr = '0;
  logic        proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, advance_n = 1'b1;
  logic        en_master_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
  logic        interleave_mode = 1'b1;
  logic [16:0] acc_addr;
  logic        selected, desel_pulse;

  int checks = 0, fails = 0;

  // reference state
  int m_base = 0, m_beat = 0, m_sel = 0, m_dp = 0;

  always #4 clk = ~clk;

  burst_addr_seq uut (.*);

  function automatic int ref_addr();
    int lo = m_base % 4;
    int seq_lo;
    if (interleave_mode) seq_lo = lo ^ m_beat;
    else                 seq_lo = (lo + m_beat) % 4;
    return (m_base / 4) * 4 + seq_lo;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (acc_addr !== 17'(ref_addr()) || selected !== 1'(m_sel) || desel_pulse !== 1'(m_dp)) begin
      fails++;
      $display("FAIL %s: addr=%h sel=%0d dp=%0d expected addr=%h sel=%0d dp=%0d",
               tag, acc_addr, selected, desel_pulse, ref_addr(), m_sel, m_dp);
    end
  endtask

  task automatic model_edge();
    bit pe = !proc_strobe_n && !en_master_n;
    bit en_ok = !en_master_n && en_hi && !en_lo_n;
    if (!rst_n) begin
      m_base = 0; m_beat = 0; m_sel = 0; m_dp = 0;
    end else if (pe || !ctrl_strobe_n) begin
      if (en_ok) begin m_base = int'(ext_addr); m_beat = 0; m_sel = 1; m_dp = 0; end
      else       begin m_sel = 0; m_dp = 1; end
    end else begin
      m_dp = 0;
      if (proc_strobe_n && ctrl_strobe_n && !advance_n && m_sel != 0) m_beat = (m_beat + 1) % 4;
    end
  endtask

  // drive at negedge, let one edge pass, compare at next negedge
  task automatic cyc(input bit p_n, input bit c_n, input bit a_n, input bit m_n,
                     input bit hi, input bit lo_n, input logic [16:0] a, input string tag);
    proc_strobe_n = p_n; ctrl_strobe_n = c_n; advance_n = a_n;
    en_master_n = m_n; en_hi = hi; en_lo_n = lo_n; ext_addr = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run hung, expected completion");
      end
      begin
        @(negedge clk);
        cyc(1,1,1,0,1,0,17'h0,"R10 reset");
        cyc(1,1,0,0,1,0,17'h0,"R10 reset held");
        rst_n = 1'b1;
        cyc(1,1,1,0,1,0,17'h0,"R10 after reset");
        // R11 advance while deselected
        cyc(1,1,0,0,1,0,17'h0,"R11 advance deselected");
        // R1/R4 proc load with advance low, interleaved start 2
        interleave_mode = 1'b1;
        cyc(0,1,0,0,1,0,17'h0_1236,"R1 R4 proc load");
        for (int i = 0; i < 5; i++) cyc(1,1,0,0,1,0,17'h0,"R6 R9 interleaved burst");
        // R5 suspend
        cyc(1,1,1,0,1,0,17'h0,"R5 suspend");
        cyc(1,1,1,0,1,0,17'h0,"R5 suspend again");
        cyc(1,1,0,0,1,0,17'h0,"R5 resume");
        // R2 blocked processor strobe
        cyc(0,1,1,1,1,0,17'h1_5555,"R2 proc blocked");
        cyc(0,1,0,1,0,1,17'h1_5555,"R2 proc blocked advance");
        // R3 controller load with master active
        interleave_mode = 1'b0;
        cyc(1,0,0,0,1,0,17'h1_FFFF,"R3 ctrl load");
        for (int i = 0; i < 5; i++) cyc(1,1,0,0,1,0,17'h0,"R6 R7 R9 linear burst");
        // R3 controller with master inactive deselects
        cyc(1,0,0,1,1,0,17'h0_0001,"R3 R8 ctrl master off");
        cyc(1,1,1,0,1,0,17'h0,"R8 pulse drops");
        cyc(1,1,0,0,1,0,17'h0,"R11 advance deselected");
        // reload, then each enable inactive
        cyc(0,1,1,0,1,0,17'h0_00A5,"R1 reload");
        cyc(1,1,0,0,1,0,17'h0,"R6 linear beat");
        cyc(0,1,1,0,0,0,17'h0_0F00,"R8 second enable off");
        cyc(1,0,1,0,1,0,17'h0_0331,"R3 ctrl reload");
        cyc(0,0,1,0,1,1,17'h0_0F00,"R8 third enable off");
        cyc(0,0,1,0,1,0,17'h1_0002,"R3 both strobes load");
        interleave_mode = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1,1,0,0,1,0,17'h0,"R6 R9 interleaved from 2");
        cyc(0,1,0,0,1,0,17'h0,"R1 load zero");
        cyc(1,0,0,0,1,0,17'h0,"R4 ctrl low no advance");
        disable fork;
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule